// File: doc/BRIEF.md
# Transmit Control Word Serializer for a 2B1Q Line Front End

This block sits on the host side of the transmit link to an analog line front end. It runs from a free-running oversampling clock and divides it into baud periods of 48 cycles each. From that count it produces a baud clock with a 50% duty cycle. The baud clock falls at the start of each baud period.

A control word is offered on a valid/ready port as separate fields: transmit enable, a 2-bit line symbol, a 3-bit receive gain code, a loopback flag and a boost flag. The block holds at most one offered word. It takes that word into use only when a new baud period begins. If no new word is waiting, the word from the previous baud is sent again.

In each baud period the 16-bit word goes out serially, MSB first, in the first 16 bit slots. The line stays low for the remaining 32 slots. The serial line and the baud clock change only on falling edges of the oversampling clock, so the far end can sample both on rising edges.

Top module: `afe_tx_serializer`

## Requirements
- R1: One baud period is exactly 48 cycles of `clk_os`. `baud_clk` is low for the first 24 slots and high for the last 24. It falls only at the falling clock edge that opens slot 0.
- R2: In slots 0 to 15 `ser_data` carries the word MSB first. Word bit 15 is `tx_on`, bits 14:13 are `tx_sym[1:0]`, bits 12:10 are `rx_gain[2:0]`, bit 9 is `loop_back` and bit 8 is `tx_boost`. Bit 15 is sent in slot 0.
- R3: Word bits 7:0 are reserved and are always sent as 0.
- R4: `ser_data` is 0 in slots 16 to 47.
- R5: When `tx_on` is 0, the symbol bits are still sent exactly as they were loaded.
- R6: A word is taken into use only at the start of a baud period. A word accepted while a baud is in progress does not change the bits of that baud; it appears in the next one.
- R7: `in_ready` is 1 exactly when the single holding slot is empty. A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Once a word is accepted, `in_ready` stays 0 until the next baud start frees the slot. Field inputs while `in_valid` is 0 are ignored. Back-pressure may last up to one full baud period.
- R8: If no new word is waiting at a baud start, the previous word is sent again. After reset, `in_ready` is 1, `baud_clk` is 1 and `ser_data` is 0, and the word in use is all zeros until the first accepted word takes effect.
- R9: `ser_data` and `baud_clk` change only on falling edges of `clk_os`, so both are stable across every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_os | input | 1 | Continuous oversampling clock, 48 times the baud rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Offered control word is valid |
| in_ready | output | 1 | Holding slot is empty; the word is accepted on this edge |
| tx_on | input | 1 | Transmit enable field |
| tx_sym | input | 2 | Line symbol field |
| rx_gain | input | 3 | Receive gain code field |
| loop_back | input | 1 | Loopback flag field |
| tx_boost | input | 1 | Transmit boost flag field |
| ser_data | output | 1 | Serial control word, driven on falling edges |
| baud_clk | output | 1 | Baud clock, falls at each baud start |

## Verification
The bench offers a word while a baud is being shifted out. A design that latches too early would send a mixed word in that baud, and one that latches too late would lose a baud. It offers a second word while the holding slot is full. A design with broken back-pressure would overwrite the waiting word or drop the second one, and the serial stream would show the wrong order. It also sends a word with the enable bit clear and the symbol bits set, which catches a serializer that masks the symbol. It checks that the tail slots are quiet, that a word repeats when no new one arrives, and that line and baud edges never land on a rising clock edge, which catches slipped framing and outputs timed on the wrong edge.

// File: rtl/afe_tx_pkg.sv
package afe_tx_pkg;
  localparam int unsigned FIELD_BITS = 8;

  // Meaningful upper byte of the control word, MSB first.
  typedef struct packed {
    logic       tx_on;
    logic [1:0] sym;
    logic [2:0] gain;
    logic       loop_back;
    logic       boost;
  } ctrl_fields_t;
endpackage

// File: rtl/afe_baud_divider.sv
module afe_baud_divider #(
  parameter int unsigned BAUD_CYCLES = 48,
  parameter int unsigned LOW_SLOTS   = 24,
  parameter int unsigned SLOT_W      = $clog2(BAUD_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic              baud_start,
  output logic              baud_level
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BAUD_CYCLES - 1);
  localparam logic [SLOT_W-1:0] HIGH_FROM = SLOT_W'(LOW_SLOTS);

  // Reset to the last slot so the first rising edge opens baud 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                slot <= LAST_SLOT;
    else if (slot == LAST_SLOT) slot <= '0;
    else                       slot <= slot + 1'b1;
  end

  assign baud_start = (slot == LAST_SLOT);
  assign baud_level = (slot >= HIGH_FROM);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == LAST_SLOT) |=> (slot == '0));
  assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot <= LAST_SLOT));
endmodule

// File: rtl/afe_word_stage.sv
module afe_word_stage #(
  parameter int unsigned WORD_BITS = 16,
  parameter int unsigned ZERO_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_BITS-1:0] in_word,
  input  logic                 baud_start,
  output logic [WORD_BITS-1:0] load_word
);
  logic                 pend_full;
  logic [WORD_BITS-1:0] pend_word;
  logic [WORD_BITS-1:0] live_word;

  assign in_ready  = !pend_full;
  assign load_word = pend_full ? pend_word : live_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_word <= '0;
      live_word <= '0;
    end else begin
      if (baud_start) live_word <= load_word;
      if (in_valid && in_ready) begin
        pend_full <= 1'b1;
        pend_word <= in_word;
      end else if (baud_start) begin
        pend_full <= 1'b0;
      end
    end
  end

  assert_accept_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_hold_mid_baud_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_start |=> $stable(live_word));
  assert_repeat_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_start && !pend_full) |=> $stable(live_word));
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_word[ZERO_BITS-1:0] == '0));
endmodule

// File: rtl/afe_word_shifter.sv
module afe_word_shifter #(
  parameter int unsigned WORD_BITS = 16,
  parameter int unsigned SLOT_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_start,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [WORD_BITS-1:0] load_word,
  output logic                 bit_now
);
  localparam logic [SLOT_W-1:0] WORD_END   = SLOT_W'(WORD_BITS);
  localparam logic [SLOT_W-1:0] SHIFT_STOP = SLOT_W'(WORD_BITS - 1);

  logic [WORD_BITS-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sreg <= '0;
    else if (baud_start)         sreg <= load_word;
    else if (slot < SHIFT_STOP)  sreg <= {sreg[WORD_BITS-2:0], 1'b0};
  end

  // The slot count gates the tail slots, which stay quiet.
  assign bit_now = (slot < WORD_END) ? sreg[WORD_BITS-1] : 1'b0;
endmodule

// File: rtl/afe_pin_retimer.sv
module afe_pin_retimer (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_now,
  input  logic baud_level,
  output logic ser_q,
  output logic baud_q
);
  // Falling-edge launch: the pins settle half a cycle before the far end samples.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q  <= 1'b0;
      baud_q <= 1'b1;
    end else begin
      ser_q  <= bit_now;
      baud_q <= baud_level;
    end
  end
endmodule

// File: rtl/afe_tx_serializer.sv
module afe_tx_serializer
  import afe_tx_pkg::*;
#(
  parameter int unsigned BAUD_CYCLES = 48,
  parameter int unsigned WORD_BITS   = 16
) (
  input  logic       clk_os,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       tx_on,
  input  logic [1:0] tx_sym,
  input  logic [2:0] rx_gain,
  input  logic       loop_back,
  input  logic       tx_boost,
  output logic       ser_data,
  output logic       baud_clk
);
  localparam int unsigned SLOT_W    = $clog2(BAUD_CYCLES);
  localparam int unsigned LOW_SLOTS = BAUD_CYCLES / 2;
  localparam int unsigned ZERO_BITS = WORD_BITS - FIELD_BITS;
  localparam logic [SLOT_W-1:0] WORD_END = SLOT_W'(WORD_BITS);

  ctrl_fields_t          fields;
  logic [WORD_BITS-1:0]  in_word;
  logic [WORD_BITS-1:0]  load_word;
  logic [SLOT_W-1:0]     slot;
  logic                  baud_start;
  logic                  baud_level;
  logic                  bit_now;

  assign fields  = '{tx_on: tx_on, sym: tx_sym, gain: rx_gain,
                     loop_back: loop_back, boost: tx_boost};
  assign in_word = {fields, {ZERO_BITS{1'b0}}};

  afe_baud_divider #(.BAUD_CYCLES(BAUD_CYCLES), .LOW_SLOTS(LOW_SLOTS), .SLOT_W(SLOT_W))
    div_i (.clk(clk_os), .rst_n(rst_n), .slot(slot), .baud_start(baud_start),
           .baud_level(baud_level));

  afe_word_stage #(.WORD_BITS(WORD_BITS), .ZERO_BITS(ZERO_BITS))
    stage_i (.clk(clk_os), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
             .in_word(in_word), .baud_start(baud_start), .load_word(load_word));

  afe_word_shifter #(.WORD_BITS(WORD_BITS), .SLOT_W(SLOT_W))
    shift_i (.clk(clk_os), .rst_n(rst_n), .baud_start(baud_start), .slot(slot),
             .load_word(load_word), .bit_now(bit_now));

  afe_pin_retimer pins_i (.clk(clk_os), .rst_n(rst_n), .bit_now(bit_now),
                          .baud_level(baud_level), .ser_q(ser_data), .baud_q(baud_clk));

  // The pins launched on the falling edge of slot k are seen on the next rising edge.
  assert_tail_quiet_R4: assert property (@(posedge clk_os) disable iff (!rst_n)
    (slot >= WORD_END) |-> !ser_data);
  assert_baud_fall_R1: assert property (@(posedge clk_os) disable iff (!rst_n)
    $fell(baud_clk) |-> (slot == '0));
endmodule

// File: tb/afe_tx_serializer_tb_top.sv
module afe_tx_serializer_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, in_ready;
  logic tx_on = 1'b0, loop_back = 1'b0, tx_boost = 1'b0;
  logic [1:0] tx_sym = '0;
  logic [2:0] rx_gain = '0;
  logic ser_data, baud_clk;
  int n_chk = 0, n_bad = 0;

  afe_tx_serializer dut_i (.clk_os(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_ready(in_ready), .tx_on(tx_on), .tx_sym(tx_sym), .rx_gain(rx_gain),
    .loop_back(loop_back), .tx_boost(tx_boost), .ser_data(ser_data), .baud_clk(baud_clk));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic e, input logic [1:0] s,
      input logic [2:0] g, input logic l, input logic b);
    return {e, s, g, l, b, 8'h00};
  endfunction

  // One baud: word bits, tail quiet, baud shape, stability across rising edges.
  task automatic capture_frame(output logic [15:0] w, output bit tail_ok,
                               output bit baud_ok, output bit stab_ok);
    logic a, ab;
    w = '0; tail_ok = 1; baud_ok = 1; stab_ok = 1;
    @(negedge baud_clk);
    for (int k = 0; k < 48; k++) begin
      if (k > 0) @(negedge clk);
      #2; a = ser_data; ab = baud_clk;
      @(posedge clk); #1;
      if (ser_data !== a || baud_clk !== ab) stab_ok = 0;
      if (k < 16) w[15-k] = ser_data;
      else if (ser_data !== 1'b0) tail_ok = 0;
      if (baud_clk !== (k >= 24)) baud_ok = 0;
    end
  endtask

  task automatic check_frame(input logic [15:0] exp, input string tag);
    logic [15:0] w; bit t, b, s;
    capture_frame(w, t, b, s);
    check(w == exp, "R2", {tag, " word"}, 32'(w), 32'(exp));
    check(w[7:0] == 8'h00, "R3", {tag, " reserved"}, 32'(w[7:0]), 0);
    check(t, "R4", {tag, " tail"}, 32'(t), 1);
    check(b, "R1", {tag, " baud shape"}, 32'(b), 1);
    check(s, "R9", {tag, " stability"}, 32'(s), 1);
  endtask

  task automatic push(input logic e, input logic [1:0] s, input logic [2:0] g,
                      input logic l, input logic b);
    logic r;
    @(negedge clk);
    tx_on = e; tx_sym = s; rx_gain = g; loop_back = l; tx_boost = b; in_valid = 1'b1;
    forever begin
      r = in_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic mid_baud();
    @(negedge baud_clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check(in_ready === 1'b1, "R8", "ready after reset", 32'(in_ready), 1);
    check(baud_clk === 1'b1 && ser_data === 1'b0, "R8", "pins after reset",
          {30'd0, baud_clk, ser_data}, 32'h2);
    check_frame(16'h0000, "R8 reset word");
  endtask

  task automatic t_patterns();
    mid_baud(); push(1, 2'd2, 3'd5, 0, 1);
    check_frame(exp_word(1, 2'd2, 3'd5, 0, 1), "pattern A");
    mid_baud(); push(1, 2'd1, 3'd7, 1, 1);
    check_frame(exp_word(1, 2'd1, 3'd7, 1, 1), "pattern B");
  endtask

  task automatic t_disabled_symbol();
    logic [15:0] w; bit t, b, s;
    mid_baud(); push(0, 2'd3, 3'd2, 1, 0);
    capture_frame(w, t, b, s);
    check(w[15] == 1'b0 && w[14:13] == 2'b11, "R5", "symbol kept with enable off",
          32'(w[15:13]), 32'h3);
    check(w == exp_word(0, 2'd3, 3'd2, 1, 0), "R5", "full word enable off",
          32'(w), 32'(exp_word(0, 2'd3, 3'd2, 1, 0)));
  endtask

  task automatic t_repeat();
    check_frame(exp_word(0, 2'd3, 3'd2, 1, 0), "R8 repeat 1");
    check_frame(exp_word(0, 2'd3, 3'd2, 1, 0), "R8 repeat 2");
  endtask

  task automatic t_midword();
    logic [15:0] w; bit t, b, s;
    fork
      capture_frame(w, t, b, s);
      begin
        @(negedge baud_clk); repeat (6) @(posedge clk);
        push(1, 2'd0, 3'd1, 0, 0);
        @(negedge clk); tx_on = 0; tx_sym = 2'd3; rx_gain = 3'd6; loop_back = 1; tx_boost = 1;
      end
    join
    check(w == exp_word(0, 2'd3, 3'd2, 1, 0), "R6", "current baud untouched",
          32'(w), 32'(exp_word(0, 2'd3, 3'd2, 1, 0)));
    capture_frame(w, t, b, s);
    check(w == exp_word(1, 2'd0, 3'd1, 0, 0), "R6", "new word next baud, R7 idle fields ignored",
          32'(w), 32'(exp_word(1, 2'd0, 3'd1, 0, 0)));
  endtask

  task automatic t_backpressure();
    logic [15:0] w; bit t, b, s;
    mid_baud(); push(1, 2'd3, 3'd4, 1, 0);
    @(negedge clk);
    check(in_ready === 1'b0, "R7", "ready low while slot full", 32'(in_ready), 0);
    repeat (10) @(negedge clk);
    check(in_ready === 1'b0, "R7", "ready held low mid baud", 32'(in_ready), 0);
    fork
      push(0, 2'd1, 3'd3, 0, 1);
      capture_frame(w, t, b, s);
    join
    check(w == exp_word(1, 2'd3, 3'd4, 1, 0), "R7", "first waiting word",
          32'(w), 32'(exp_word(1, 2'd3, 3'd4, 1, 0)));
    capture_frame(w, t, b, s);
    check(w == exp_word(0, 2'd1, 3'd3, 0, 1), "R7", "blocked word after release",
          32'(w), 32'(exp_word(0, 2'd1, 3'd3, 0, 1)));
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_disabled_symbol();
    t_repeat();
    t_midword();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run hung act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule